// File: doc/BRIEF.md
# Indexed Chipset Configuration and Upper-Memory Shadow Decoder

This block sits in the core logic of an AT-class system. Software reaches it through two I/O ports. A write to the index port (22h) selects one of six 8-bit configuration registers. The data port (23h) then reads or writes the selected register. Index values 10h to 15h select registers; any other index selects nothing.

From the register contents the block decodes memory attributes for five upper-memory regions. For each region it drives a read-internal flag and a write-internal flag, which the memory steering logic consumes. It also drives the DRAM refresh enable. The attribute outputs are combinational over the register flops, so a new setting takes effect on the clock edge that completes the data-port write.

The I/O side uses a single-cycle strobe. Read data is registered and appears one cycle after the strobe, together with an acknowledge for the two ports the block claims.

Top module: `shadow_cfg_dec`

## Requirements
- R1: A write to port 22h loads the 8-bit index. A data-port (23h) write or read acts on the register the index selects, with 10h..15h mapping to registers 0..5. A write to any other address leaves the index unchanged.
- R2: A data-port write while the index is outside 10h..15h changes no register and no output. A data-port read while the index is outside that range returns FFh.
- R3: A data-port write stores the value ANDed with a per-register mask: DFh for 10h, F0h for 11h, FEh for 12h, FFh for 13h, 14h and 15h.
- R4: After reset every register is 00h except 13h, which is 01h, and the index is 00h.
- R5: Region bit positions in rd_int_o/wr_int_o are 0=A0000-BFFFF, 1=C0000, 2=D0000, 3=E0000, 4=F0000. Register 10h bit 0 sets both bit 0 flags.
- R6: refresh_en_o is the inverse of register 10h bit 4.
- R7: rd_int_o[1] = 15h bit 1 AND 14h bit 5. wr_int_o[1] additionally requires 15h bit 0.
- R8: rd_int_o[2] = 15h bit 3 AND 14h bit 5. wr_int_o[2] additionally requires 15h bit 2.
- R9: rd_int_o[3] = 15h bit 5. wr_int_o[3] = 15h bit 5 AND 15h bit 4.
- R10: rd_int_o[4] = 15h bit 6 and wr_int_o[4] = NOT 15h bit 6, so after reset F0000 is write-internal and read-external.
- R11: One cycle after an io_rd_i strobe, rd_ack_o is 1 for addresses 22h and 23h and 0 otherwise. In the same cycle rd_data_o holds FFh for port 22h and the register value for port 23h. Otherwise rd_ack_o is 0.
- R12: The attribute and refresh outputs change only on the clock edge that completes a data-port write, and take the new value at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_wr_i | input | 1 | I/O write strobe, one cycle |
| io_rd_i | input | 1 | I/O read strobe, one cycle |
| io_addr_i | input | 16 | I/O address |
| io_wdata_i | input | 8 | I/O write data |
| rd_data_o | output | 8 | Registered read data |
| rd_ack_o | output | 1 | Read claimed, valid with rd_data_o |
| rd_int_o | output | 5 | Per-region read-internal flags |
| wr_int_o | output | 5 | Per-region write-internal flags |
| refresh_en_o | output | 1 | DRAM refresh enable |

## Verification
A corrupted register or index shows at the ports on the next data-port read, one cycle after the strobe. Where the bits feed the decoder, it shows at once on the attribute outputs. A wrong mask or reset value shows as a wrong read-back value. A wrong cross-register gate shows only under particular combinations of 14h bit 5 and the 15h bits, so the bench steps through those combinations and checks every region flag after each write. A lost or stale index write shows as a read or write landing on the wrong register, which the read-back exposes within two cycles.

// File: rtl/shadow_cfg_pkg.sv
package shadow_cfg_pkg;
  localparam int NUM_REGS  = 6;
  localparam int NUM_RGN   = 5;
  localparam int DATA_W    = 8;

  // region slots in the attribute vectors
  localparam int RGN_VID = 0;
  localparam int RGN_C   = 1;
  localparam int RGN_D   = 2;
  localparam int RGN_E   = 3;
  localparam int RGN_F   = 4;

  // register slots relative to the index base
  localparam int SLOT_SYS   = 0;
  localparam int SLOT_CACHE = 1;
  localparam int SLOT_NCA   = 2;
  localparam int SLOT_BANK  = 3;
  localparam int SLOT_DRAM  = 4;
  localparam int SLOT_SHAD  = 5;

  typedef logic [DATA_W-1:0] byte_t;

  function automatic byte_t slot_mask(input int slot);
    case (slot)
      SLOT_SYS:   return 8'hDF;
      SLOT_CACHE: return 8'hF0;
      SLOT_NCA:   return 8'hFE;
      default:    return 8'hFF;
    endcase
  endfunction

  function automatic byte_t slot_reset(input int slot);
    return (slot == SLOT_BANK) ? 8'h01 : 8'h00;
  endfunction
endpackage

// File: rtl/scfg_port_dec.sv
module scfg_port_dec
  import shadow_cfg_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] IDX_PORT  = 16'h0022,
  parameter logic [15:0] DATA_PORT = 16'h0023,
  parameter byte_t       IDX_BASE  = 8'h10,
  localparam int         SEL_W     = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_wr_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  byte_t             io_wdata_i,
  output logic              idx_hit_o,
  output logic              data_hit_o,
  output logic              sel_valid_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [NUM_REGS-1:0] wr_sel_o
);
  byte_t idx_q;
  byte_t off;

  assign idx_hit_o  = (io_addr_i == ADDR_W'(IDX_PORT));
  assign data_hit_o = (io_addr_i == ADDR_W'(DATA_PORT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   idx_q <= '0;
    else if (io_wr_i && idx_hit_o) idx_q <= io_wdata_i;
  end

  assign off         = idx_q - IDX_BASE;
  assign sel_valid_o = (idx_q >= IDX_BASE) && (off < 8'(NUM_REGS));
  assign sel_o       = off[SEL_W-1:0];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_wsel
    assign wr_sel_o[i] = io_wr_i && data_hit_o && sel_valid_o &&
                         (sel_o == SEL_W'(i));
  end
endmodule

// File: rtl/scfg_regfile.sv
module scfg_regfile
  import shadow_cfg_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_REGS-1:0]  wr_sel_i,
  input  byte_t                wdata_i,
  output byte_t [NUM_REGS-1:0] regs_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam byte_t MASK = slot_mask(i);
    localparam byte_t RVAL = slot_reset(i);
    byte_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          q <= RVAL;
      else if (wr_sel_i[i]) q <= wdata_i & MASK;
    end
    assign regs_o[i] = q;
  end
endmodule

// File: rtl/scfg_attr_dec.sv
module scfg_attr_dec
  import shadow_cfg_pkg::*;
(
  input  byte_t [NUM_REGS-1:0] regs_i,
  output logic [NUM_RGN-1:0]   rd_int_o,
  output logic [NUM_RGN-1:0]   wr_int_o,
  output logic                 refresh_en_o
);
  byte_t sys, dram, shad;
  logic  rom_gate;

  assign sys  = regs_i[SLOT_SYS];
  assign dram = regs_i[SLOT_DRAM];
  assign shad = regs_i[SLOT_SHAD];

  // global gate for the two option-ROM windows
  assign rom_gate = dram[5];

  always_comb begin
    rd_int_o = '0;
    wr_int_o = '0;
    rd_int_o[RGN_VID] = sys[0];
    wr_int_o[RGN_VID] = sys[0];
    rd_int_o[RGN_C]   = rom_gate & shad[1];
    wr_int_o[RGN_C]   = rom_gate & shad[1] & shad[0];
    rd_int_o[RGN_D]   = rom_gate & shad[3];
    wr_int_o[RGN_D]   = rom_gate & shad[3] & shad[2];
    rd_int_o[RGN_E]   = shad[5];
    wr_int_o[RGN_E]   = shad[5] & shad[4];
    // BIOS window: read and write sources are mutually exclusive
    rd_int_o[RGN_F]   = shad[6];
    wr_int_o[RGN_F]   = ~shad[6];
  end

  assign refresh_en_o = ~sys[4];
endmodule

// File: rtl/shadow_cfg_dec.sv
module shadow_cfg_dec
  import shadow_cfg_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] IDX_PORT  = 16'h0022,
  parameter logic [15:0] DATA_PORT = 16'h0023,
  parameter logic [7:0]  IDX_BASE  = 8'h10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic [7:0]        io_wdata_i,
  output logic [7:0]        rd_data_o,
  output logic              rd_ack_o,
  output logic [4:0]        rd_int_o,
  output logic [4:0]        wr_int_o,
  output logic              refresh_en_o
);
  localparam int SEL_W = $clog2(NUM_REGS);

  logic                 idx_hit, data_hit, sel_valid;
  logic [SEL_W-1:0]     sel;
  logic [NUM_REGS-1:0]  wr_sel;
  byte_t [NUM_REGS-1:0] regs;
  byte_t                rdata_d;

  scfg_port_dec #(
    .ADDR_W(ADDR_W), .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT), .IDX_BASE(IDX_BASE)
  ) u_port (
    .clk_i, .rst_ni, .io_wr_i, .io_addr_i, .io_wdata_i,
    .idx_hit_o(idx_hit), .data_hit_o(data_hit), .sel_valid_o(sel_valid),
    .sel_o(sel), .wr_sel_o(wr_sel)
  );

  scfg_regfile u_regs (
    .clk_i, .rst_ni, .wr_sel_i(wr_sel), .wdata_i(io_wdata_i), .regs_o(regs)
  );

  scfg_attr_dec u_attr (
    .regs_i(regs), .rd_int_o, .wr_int_o, .refresh_en_o
  );

  always_comb begin
    rdata_d = 8'hFF;
    if (data_hit && sel_valid) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (sel == SEL_W'(i)) rdata_d = regs[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o <= 8'hFF;
      rd_ack_o  <= 1'b0;
    end else begin
      rd_ack_o <= io_rd_i && (idx_hit || data_hit);
      if (io_rd_i) rd_data_o <= rdata_d;
    end
  end
endmodule

// File: rtl/scfg_chk.sv
module scfg_chk #(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] IDX_PORT  = 16'h0022,
  parameter logic [15:0] DATA_PORT = 16'h0023,
  parameter logic [7:0]  IDX_BASE  = 8'h10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              io_wr_i,
  input logic              io_rd_i,
  input logic [ADDR_W-1:0] io_addr_i,
  input logic [7:0]        io_wdata_i,
  input logic [7:0]        rd_data_o,
  input logic              rd_ack_o,
  input logic [4:0]        rd_int_o,
  input logic [4:0]        wr_int_o,
  input logic              refresh_en_o
);
  logic [7:0] idx_seen;
  logic       a_idx, a_dat, idx_ok;

  assign a_idx  = (io_addr_i == ADDR_W'(IDX_PORT));
  assign a_dat  = (io_addr_i == ADDR_W'(DATA_PORT));
  assign idx_ok = (idx_seen >= IDX_BASE) && (idx_seen < IDX_BASE + 8'd6);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              idx_seen <= '0;
    else if (io_wr_i && a_idx) idx_seen <= io_wdata_i;
  end

  assert_bad_idx_wr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_wr_i && a_dat && !idx_ok |=> $stable(rd_int_o) && $stable(wr_int_o) && $stable(refresh_en_o));
  assert_bad_idx_rd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rd_i && a_dat && !idx_ok |=> rd_ack_o && rd_data_o == 8'hFF);
  assert_refresh_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_wr_i && a_dat && idx_seen == IDX_BASE |=> refresh_en_o == !$past(io_wdata_i[4]));
  assert_c_order_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_int_o[1] |-> rd_int_o[1]);
  assert_d_order_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_int_o[2] |-> rd_int_o[2]);
  assert_e_order_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_int_o[3] |-> rd_int_o[3]);
  assert_f_split_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_wr_i && a_dat && idx_seen == IDX_BASE + 8'd5 |=>
      wr_int_o[4] == !$past(io_wdata_i[6]) && rd_int_o[4] == $past(io_wdata_i[6]));
  assert_idx_rd_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rd_i && a_idx |=> rd_ack_o && rd_data_o == 8'hFF);
  assert_unclaimed_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_rd_i && (a_idx || a_dat)) |=> !rd_ack_o);
  assert_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_wr_i && a_dat) |=> $stable(rd_int_o) && $stable(wr_int_o) && $stable(refresh_en_o));
endmodule

bind shadow_cfg_dec scfg_chk #(
  .ADDR_W(ADDR_W), .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT), .IDX_BASE(IDX_BASE)
) u_chk (.*);

// File: tb/shadow_cfg_dec_test.sv
module shadow_cfg_dec_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  rd_data;
  logic        rd_ack;
  logic [4:0]  rd_int, wr_int;
  logic        refresh_en;

  int errors = 0, checks = 0;
  logic [7:0] m [6];
  logic [7:0] idx;
  logic [8:0] exp_q [$];
  string      tag_q [$];
  logic       rd_seen = 1'b0;

  always #5 clk = ~clk;

  shadow_cfg_dec uut (
    .clk_i(clk), .rst_ni(rst_n), .io_wr_i(io_wr), .io_rd_i(io_rd),
    .io_addr_i(io_addr), .io_wdata_i(io_wdata), .rd_data_o(rd_data),
    .rd_ack_o(rd_ack), .rd_int_o(rd_int), .wr_int_o(wr_int),
    .refresh_en_o(refresh_en)
  );

  function automatic logic [7:0] mask_of(input int s);
    case (s)
      0: return 8'hDF;
      1: return 8'hF0;
      2: return 8'hFE;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [10:0] exp_attr();
    logic [4:0] r, w;
    r[0] = m[0][0];            w[0] = m[0][0];
    r[1] = m[5][1] & m[4][5];  w[1] = r[1] & m[5][0];
    r[2] = m[5][3] & m[4][5];  w[2] = r[2] & m[5][2];
    r[3] = m[5][5];            w[3] = m[5][5] & m[5][4];
    r[4] = m[5][6];            w[4] = ~m[5][6];
    return {r, w, ~m[0][4]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_attr(input string tag);
    check(tag, {21'd0, rd_int, wr_int, refresh_en}, {21'd0, exp_attr()});
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
    if (a == 16'h22) idx = d;
    else if (a == 16'h23 && idx >= 8'h10 && idx <= 8'h15)
      m[idx-8'h10] = d & mask_of(int'(idx - 8'h10));
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    logic [8:0] e;
    @(negedge clk);
    io_rd = 1'b1; io_addr = a;
    if (a == 16'h22) e = {1'b1, 8'hFF};
    else if (a == 16'h23)
      e = (idx >= 8'h10 && idx <= 8'h15) ? {1'b1, m[idx-8'h10]} : {1'b1, 8'hFF};
    else e = 9'h000;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] i, input string tag);
    wr(16'h22, i);
    rd(16'h23, tag);
  endtask

  // scoreboard monitor
  always @(posedge clk) rd_seen <= io_rd;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [8:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (e[8]) check(t, {23'd0, rd_ack, rd_data}, {23'd0, e});
      else      check(t, {31'd0, rd_ack}, 32'd0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) m[i] = (i == 3) ? 8'h01 : 8'h00;
    idx = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4/R5/R6/R10 reset attributes: F write-internal, refresh on
    check("R4 reset attrs", {21'd0, rd_int, wr_int, refresh_en}, {21'd0, 5'b00000, 5'b10000, 1'b1});
    rd(16'h23, "R2 read with reset index 00h");
    rd(16'h22, "R11 index port read");
    rd(16'h0080, "R11 unclaimed read");
    for (int i = 0; i < 6; i++) rd_reg(8'h10 + 8'(i), "R4 reset value");
    // masks
    for (int i = 0; i < 6; i++) begin
      wr(16'h22, 8'h10 + 8'(i));
      wr(16'h23, 8'hFF);
      rd(16'h23, "R3 mask all ones");
    end
    check_attr("R5 R6 R7 R8 R9 R10 all ones");
    for (int i = 0; i < 6; i++) begin
      wr(16'h22, 8'h10 + 8'(i));
      wr(16'h23, 8'h00);
    end
    check_attr("R10 cleared regs");
    // invalid index writes ignored
    wr(16'h22, 8'h16); wr(16'h23, 8'hAA); check_attr("R2 index 16h write");
    rd(16'h23, "R2 index 16h read");
    wr(16'h22, 8'h0F); wr(16'h23, 8'hFF); check_attr("R2 index 0Fh write");
    for (int i = 0; i < 6; i++) rd_reg(8'h10 + 8'(i), "R2 regs untouched");
    // index held across other-address writes
    wr(16'h22, 8'h13); wr(16'h24, 8'h55); wr(16'h23, 8'h5A);
    rd(16'h23, "R1 index held across 24h");
    // video region and refresh
    wr(16'h22, 8'h10); wr(16'h23, 8'h01); check_attr("R5 video on");
    wr(16'h23, 8'h10); check_attr("R6 refresh off");
    wr(16'h23, 8'h31); check_attr("R12 bit5 masked");
    rd(16'h23, "R3 10h mask read");
    // cross-register shadow combinations
    for (int g = 0; g < 2; g++) begin
      wr(16'h22, 8'h14); wr(16'h23, g[0] ? 8'h20 : 8'hDF);
      check_attr("R7 R8 gate change");
      for (int p = 0; p < 8; p++) begin
        logic [7:0] v;
        v = {1'b0, p[2], p[1], p[0], p[0], p[1], p[2], p[0]};
        wr(16'h22, 8'h15); wr(16'h23, v);
        check_attr("R7 R8 R9 R10 shadow pattern");
      end
    end
    wr(16'h22, 8'h15); wr(16'h23, 8'h40); check_attr("R10 F read-internal");
    wr(16'h23, 8'h30); check_attr("R9 E both");
    wr(16'h23, 8'h10); check_attr("R9 E write alone");
    wr(16'h23, 8'h03); check_attr("R7 C with gate");
    wr(16'h23, 8'h0C); check_attr("R8 D with gate");
    wr(16'h22, 8'h14); wr(16'h23, 8'h00); check_attr("R12 gate drop");
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule